// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN or CAN FD frame should be kept, based only on its identifier. It holds two rule lists: one tested against 11-bit standard identifiers and one tested against 29-bit extended identifiers. Each rule has a match kind, two identifier fields and an action code. The frame's identifier-extension flag picks which list is searched.

The rules are compared in parallel. The lowest-numbered rule that matches wins. The block returns that rule's index and action code one clock later. An action code of zero means "reject". Any other value is passed on for downstream logic to use, for example to choose a receive queue. A frame that matches no rule is rejected.

Rule contents can be rewritten at any time through a single write port. The number of rules that take part in the search is held in two count registers. These registers accept a new value only while the configuration-init input is high.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every output is 0, both rule counts are 0 and every rule is all-zero, so the first frame sent produces no hit.
- R2: A frame presented with `frm_valid` high at a clock edge yields `res_valid` high on the next edge, for exactly one cycle; without a frame, `res_valid` stays low.
- R3: Match kind 0 (pair): the rule hits when the key equals the first field or the second field.
- R4: Match kind 1 (range): the rule hits when first field <= key <= second field, with both bounds included.
- R5: Match kind 2 (mask): the rule hits when every key bit selected by a 1 in the second field equals the same bit of the first field.
- R6: Match kind 3 never hits. A rule whose kind, action and both fields are all zero is disabled and never hits.
- R7: When several rules hit, the one with the lowest index is reported.
- R8: Only rules with index below the list's count are searched. A count written above the list depth (28 standard, 8 extended) is clamped to that depth.
- R9: Count writes (`cfg_wr`) take effect only while `cfg_init` is high. Rule writes take effect whether `cfg_init` is high or low.
- R10: A frame with `frm_ext`=0 is searched only in the standard list, using `frm_id[10:0]`. A frame with `frm_ext`=1 is searched only in the extended list, using `frm_id[28:0]`.
- R11: A standard rule stores only bits 10:0 of `wr_id1` and `wr_id2`. Higher bits are dropped.
- R12: On a hit, `res_index` and `res_action` give the winning rule, and `res_accept` = (`res_action` != 0). On a miss, or when `res_valid` is low, `res_hit`, `res_accept`, `res_index` and `res_action` are all 0.
- R13: A rule write whose `wr_idx` is not below the selected list's depth changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_init | input | 1 | Configuration-init flag; unlocks count writes |
| cfg_wr | input | 1 | Write strobe for both rule counts |
| cfg_std_cnt | input | 5 | New standard-list rule count |
| cfg_ext_cnt | input | 4 | New extended-list rule count |
| wr_en | input | 1 | Rule write strobe |
| wr_ext | input | 1 | Rule write target: 0 standard list, 1 extended list |
| wr_idx | input | 5 | Index of the rule to write |
| wr_type | input | 2 | Match kind: 0 pair, 1 range, 2 mask, 3 off |
| wr_act | input | 3 | Action code; 0 means reject |
| wr_id1 | input | 29 | First identifier field (value, lower bound or pattern) |
| wr_id2 | input | 29 | Second identifier field (value, upper bound or mask) |
| frm_valid | input | 1 | A frame identifier is present |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_id | input | 29 | Frame identifier |
| res_valid | output | 1 | Result for the frame from the previous cycle |
| res_hit | output | 1 | Some enabled rule matched |
| res_accept | output | 1 | Hit with a non-zero action |
| res_index | output | 5 | Index of the winning rule |
| res_action | output | 3 | Action code of the winning rule |

## Verification
Every result is registered once. A frame driven before edge N is therefore judged on edge N+1, using the rules and counts that were in place at edge N. Count and rule writes also take effect on the edge that captures them. The bench drives all inputs on the falling edge and reads the result on the next falling edge, half a cycle after the register updates. A write is always completed before the next frame is presented. It also checks that `res_valid` drops again one cycle after a lone frame.

// File: rtl/caf_pkg.sv
package caf_pkg;

   // How the two identifier fields of a rule are interpreted
   typedef enum logic [1:0] {
      MT_PAIR  = 2'd0,   // key equals either field
      MT_RANGE = 2'd1,   // field1 <= key <= field2
      MT_MASK  = 2'd2,   // key matches field1 on the bits set in field2
      MT_OFF   = 2'd3    // never matches
   } match_kind_e;

   // Action value that turns a hit into a rejection
   localparam int ACT_REJECT = 0;

endpackage

// File: rtl/caf_first_hit.sv
// Lowest-index selector with an attached payload per input
module caf_first_hit #(
   parameter int N     = 28,
   parameter int IDX_W = 5,
   parameter int PW    = 3
) (
   input  logic [N-1:0]         vec,
   input  logic [N-1:0][PW-1:0] pay,
   output logic                 found,
   output logic [IDX_W-1:0]     idx,
   output logic [PW-1:0]        sel
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      sel   = '0;
      // walk downwards so the lowest set position is the last one kept
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
            sel   = pay[i];
         end
      end
   end

endmodule

// File: rtl/caf_rule_bank.sv
// One list of acceptance rules: storage, parallel compare, winner pick
module caf_rule_bank
   import caf_pkg::*;
#(
   parameter int N     = 28,
   parameter int W     = 11,
   parameter int IDX_W = 5,
   parameter int CNT_W = 5,
   parameter int ACT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [1:0]       wr_type,
   input  logic [ACT_W-1:0] wr_act,
   input  logic [W-1:0]     wr_f1,
   input  logic [W-1:0]     wr_f2,
   input  logic [W-1:0]     key,
   input  logic [CNT_W-1:0] cnt,
   output logic             found,
   output logic [IDX_W-1:0] hit_idx,
   output logic [ACT_W-1:0] hit_act
);

   logic [N-1:0]            hit_vec;
   logic [N-1:0][ACT_W-1:0] act_vec;

   for (genvar g = 0; g < N; g++) begin : g_rule
      match_kind_e      kind_q;
      logic [ACT_W-1:0] act_q;
      logic [W-1:0]     f1_q;
      logic [W-1:0]     f2_q;
      logic             raw;
      logic             live;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            kind_q <= MT_PAIR;
            act_q  <= '0;
            f1_q   <= '0;
            f2_q   <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            kind_q <= match_kind_e'(wr_type);
            act_q  <= wr_act;
            f1_q   <= wr_f1;
            f2_q   <= wr_f2;
         end
      end

      always_comb begin
         case (kind_q)
            MT_PAIR:  raw = (key == f1_q) || (key == f2_q);
            MT_RANGE: raw = (key >= f1_q) && (key <= f2_q);
            MT_MASK:  raw = ((key ^ f1_q) & f2_q) == '0;
            default:  raw = 1'b0;
         endcase
      end

      // inside the active count, not switched off, not an all-zero entry
      assign live = (CNT_W'(g) < cnt) && (kind_q != MT_OFF) &&
                    ({kind_q, act_q, f1_q, f2_q} != '0);

      assign hit_vec[g] = live & raw;
      assign act_vec[g] = act_q;
   end

   caf_first_hit #(
      .N    (N),
      .IDX_W(IDX_W),
      .PW   (ACT_W)
   ) u_pick (
      .vec  (hit_vec),
      .pay  (act_vec),
      .found(found),
      .idx  (hit_idx),
      .sel  (hit_act)
   );

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
   import caf_pkg::*;
#(
   parameter  int STD_RULES = 28,
   parameter  int EXT_RULES = 8,
   parameter  int STD_W     = 11,
   parameter  int EXT_W     = 29,
   parameter  int ACT_W     = 3,
   localparam int MAX_RULES = (STD_RULES > EXT_RULES) ? STD_RULES : EXT_RULES,
   localparam int IDX_W     = $clog2(MAX_RULES + 1),
   localparam int SCNT_W    = $clog2(STD_RULES + 1),
   localparam int ECNT_W    = $clog2(EXT_RULES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_init,
   input  logic              cfg_wr,
   input  logic [SCNT_W-1:0] cfg_std_cnt,
   input  logic [ECNT_W-1:0] cfg_ext_cnt,
   input  logic              wr_en,
   input  logic              wr_ext,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_type,
   input  logic [ACT_W-1:0]  wr_act,
   input  logic [EXT_W-1:0]  wr_id1,
   input  logic [EXT_W-1:0]  wr_id2,
   input  logic              frm_valid,
   input  logic              frm_ext,
   input  logic [EXT_W-1:0]  frm_id,
   output logic              res_valid,
   output logic              res_hit,
   output logic              res_accept,
   output logic [IDX_W-1:0]  res_index,
   output logic [ACT_W-1:0]  res_action
);

   // elaboration-time parameter checks
   if (STD_RULES < 1 || EXT_RULES < 1) begin : g_bad_depth
      $error("rule lists need at least one entry");
   end
   if (STD_W < 1 || STD_W >= EXT_W) begin : g_bad_width
      $error("standard identifier must be narrower than extended");
   end
   if (ACT_W < 1) begin : g_bad_act
      $error("action code needs at least one bit");
   end

   // ---------------- rule counts, locked outside init ----------------
   logic [SCNT_W-1:0] std_cnt_q;
   logic [ECNT_W-1:0] ext_cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         std_cnt_q <= '0;
         ext_cnt_q <= '0;
      end else if (cfg_wr && cfg_init) begin
         std_cnt_q <= (cfg_std_cnt > SCNT_W'(STD_RULES)) ? SCNT_W'(STD_RULES) : cfg_std_cnt;
         ext_cnt_q <= (cfg_ext_cnt > ECNT_W'(EXT_RULES)) ? ECNT_W'(EXT_RULES) : cfg_ext_cnt;
      end
   end

   // ---------------- rule write steering ----------------
   logic std_we;
   logic ext_we;

   assign std_we = wr_en && !wr_ext && (wr_idx < IDX_W'(STD_RULES));
   assign ext_we = wr_en &&  wr_ext && (wr_idx < IDX_W'(EXT_RULES));

   // ---------------- the two rule lists ----------------
   logic             std_found, ext_found;
   logic [IDX_W-1:0] std_idx,   ext_idx;
   logic [ACT_W-1:0] std_act,   ext_act;

   caf_rule_bank #(
      .N    (STD_RULES),
      .W    (STD_W),
      .IDX_W(IDX_W),
      .CNT_W(SCNT_W),
      .ACT_W(ACT_W)
   ) u_std (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (std_we),
      .wr_idx (wr_idx),
      .wr_type(wr_type),
      .wr_act (wr_act),
      .wr_f1  (wr_id1[STD_W-1:0]),
      .wr_f2  (wr_id2[STD_W-1:0]),
      .key    (frm_id[STD_W-1:0]),
      .cnt    (std_cnt_q),
      .found  (std_found),
      .hit_idx(std_idx),
      .hit_act(std_act)
   );

   caf_rule_bank #(
      .N    (EXT_RULES),
      .W    (EXT_W),
      .IDX_W(IDX_W),
      .CNT_W(ECNT_W),
      .ACT_W(ACT_W)
   ) u_ext (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ext_we),
      .wr_idx (wr_idx),
      .wr_type(wr_type),
      .wr_act (wr_act),
      .wr_f1  (wr_id1),
      .wr_f2  (wr_id2),
      .key    (frm_id),
      .cnt    (ext_cnt_q),
      .found  (ext_found),
      .hit_idx(ext_idx),
      .hit_act(ext_act)
   );

   // ---------------- list select and result register ----------------
   logic             sel_found;
   logic [IDX_W-1:0] sel_idx;
   logic [ACT_W-1:0] sel_act;

   assign sel_found = frm_ext ? ext_found : std_found;
   assign sel_idx   = frm_ext ? ext_idx   : std_idx;
   assign sel_act   = frm_ext ? ext_act   : std_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= 1'b0;
         res_accept <= 1'b0;
         res_index  <= '0;
         res_action <= '0;
      end else begin
         res_valid <= frm_valid;
         if (frm_valid && sel_found) begin
            res_hit    <= 1'b1;
            res_accept <= (sel_act != ACT_W'(ACT_REJECT));
            res_index  <= sel_idx;
            res_action <= sel_act;
         end else begin
            res_hit    <= 1'b0;
            res_accept <= 1'b0;
            res_index  <= '0;
            res_action <= '0;
         end
      end
   end

endmodule

// File: rtl/caf_check.sv
module caf_check #(
   parameter int IDX_W  = 5,
   parameter int ACT_W  = 3,
   parameter int SCNT_W = 5,
   parameter int ECNT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_init,
   input logic              frm_valid,
   input logic              frm_ext,
   input logic              res_valid,
   input logic              res_hit,
   input logic              res_accept,
   input logic [IDX_W-1:0]  res_index,
   input logic [ACT_W-1:0]  res_action,
   input logic [SCNT_W-1:0] std_cnt_q,
   input logic [ECNT_W-1:0] ext_cnt_q
);

   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> res_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> !res_valid);

   a_r12_accept_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      res_accept |-> (res_hit && res_action != '0));

   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (!res_accept && res_index == '0 && res_action == '0));

   a_r12_hit_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid);

   a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_init |=> ($stable(std_cnt_q) && $stable(ext_cnt_q)));

   a_r8_index_below_count: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> (int'(res_index) <
                   ($past(frm_ext) ? int'($past(ext_cnt_q)) : int'($past(std_cnt_q)))));

endmodule

bind can_accept_filter caf_check #(
   .IDX_W (IDX_W),
   .ACT_W (ACT_W),
   .SCNT_W(SCNT_W),
   .ECNT_W(ECNT_W)
) u_check (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_init  (cfg_init),
   .frm_valid (frm_valid),
   .frm_ext   (frm_ext),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_accept(res_accept),
   .res_index (res_index),
   .res_action(res_action),
   .std_cnt_q (std_cnt_q),
   .ext_cnt_q (ext_cnt_q)
);

// File: tb/can_accept_filter_test.sv
`timescale 1ns/1ps
module can_accept_filter_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_init, cfg_wr;
   logic [4:0]  cfg_std_cnt;
   logic [3:0]  cfg_ext_cnt;
   logic        wr_en, wr_ext;
   logic [4:0]  wr_idx;
   logic [1:0]  wr_type;
   logic [2:0]  wr_act;
   logic [28:0] wr_id1, wr_id2;
   logic        frm_valid, frm_ext;
   logic [28:0] frm_id;
   logic        res_valid, res_hit, res_accept;
   logic [4:0]  res_index;
   logic [2:0]  res_action;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   can_accept_filter uut (
      .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_wr(cfg_wr),
      .cfg_std_cnt(cfg_std_cnt), .cfg_ext_cnt(cfg_ext_cnt),
      .wr_en(wr_en), .wr_ext(wr_ext), .wr_idx(wr_idx), .wr_type(wr_type),
      .wr_act(wr_act), .wr_id1(wr_id1), .wr_id2(wr_id2),
      .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_id(frm_id),
      .res_valid(res_valid), .res_hit(res_hit), .res_accept(res_accept),
      .res_index(res_index), .res_action(res_action)
   );

   // ---------------- reference model ----------------
   logic [1:0]  mt_s[28];
   logic [2:0]  ma_s[28];
   logic [28:0] m1_s[28], m2_s[28];
   logic [1:0]  mt_e[8];
   logic [2:0]  ma_e[8];
   logic [28:0] m1_e[8], m2_e[8];
   int          mcnt_s = 0, mcnt_e = 0;

   function automatic bit rule_hits(logic [1:0] t, logic [2:0] a,
                                    logic [28:0] f1, logic [28:0] f2, logic [28:0] key);
      if (t == 2'd3) return 1'b0;
      if (t == 2'd0 && a == 3'd0 && f1 == 29'd0 && f2 == 29'd0) return 1'b0;
      case (t)
         2'd0:    return (key == f1) || (key == f2);
         2'd1:    return (key >= f1) && (key <= f2);
         default: return ((key ^ f1) & f2) == 29'd0;
      endcase
   endfunction

   function automatic void predict(input bit ext, input logic [28:0] id,
                                   output bit hit, output int idx, output logic [2:0] act);
      logic [28:0] key;
      int          n;
      key = ext ? id : (id & 29'h7FF);
      n   = ext ? mcnt_e : mcnt_s;
      hit = 1'b0; idx = 0; act = 3'd0;
      for (int i = n - 1; i >= 0; i--) begin
         bit h;
         if (ext) h = rule_hits(mt_e[i], ma_e[i], m1_e[i], m2_e[i], key);
         else     h = rule_hits(mt_s[i], ma_s[i], m1_s[i], m2_s[i], key);
         if (h) begin
            hit = 1'b1; idx = i;
            act = ext ? ma_e[i] : ma_s[i];
         end
      end
   endfunction

   // ---------------- check helper ----------------
   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- stimulus tasks ----------------
   task automatic write_rule(bit ext, int idx, int t, int a, logic [28:0] f1, logic [28:0] f2);
      @(negedge clk);
      wr_en = 1'b1; wr_ext = ext; wr_idx = 5'(idx); wr_type = 2'(t);
      wr_act = 3'(a); wr_id1 = f1; wr_id2 = f2;
      @(negedge clk);
      wr_en = 1'b0;
      if (ext && idx < 8) begin
         mt_e[idx] = 2'(t); ma_e[idx] = 3'(a); m1_e[idx] = f1; m2_e[idx] = f2;
      end else if (!ext && idx < 28) begin
         mt_s[idx] = 2'(t); ma_s[idx] = 3'(a);
         m1_s[idx] = f1 & 29'h7FF; m2_s[idx] = f2 & 29'h7FF;
      end
   endtask

   task automatic set_counts(bit init, int s, int e);
      @(negedge clk);
      cfg_init = init; cfg_wr = 1'b1; cfg_std_cnt = 5'(s); cfg_ext_cnt = 4'(e);
      @(negedge clk);
      cfg_wr = 1'b0;
      if (init) begin
         mcnt_s = (s > 28) ? 28 : s;
         mcnt_e = (e > 8) ? 8 : e;
      end
   endtask

   task automatic send(string req, bit ext, logic [28:0] id);
      bit          eh;
      int          ei;
      logic [2:0]  ea;
      predict(ext, id, eh, ei, ea);
      @(negedge clk);
      frm_valid = 1'b1; frm_ext = ext; frm_id = id;
      @(negedge clk);
      frm_valid = 1'b0;
      check(req, "valid", 64'(res_valid), 64'd1);
      check(req, "hit/accept/index/action",
            64'({res_hit, res_accept, res_index, res_action}),
            64'({eh, (eh && ea != 3'd0), 5'(ei), ea}));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      for (int i = 0; i < 28; i++) begin mt_s[i] = 0; ma_s[i] = 0; m1_s[i] = 0; m2_s[i] = 0; end
      for (int i = 0; i < 8; i++)  begin mt_e[i] = 0; ma_e[i] = 0; m1_e[i] = 0; m2_e[i] = 0; end
      void'($urandom(32'd4242));
      rst_n = 1'b0; cfg_init = 1'b0; cfg_wr = 1'b0; cfg_std_cnt = 0; cfg_ext_cnt = 0;
      wr_en = 1'b0; wr_ext = 1'b0; wr_idx = 0; wr_type = 0; wr_act = 0; wr_id1 = 0; wr_id2 = 0;
      frm_valid = 1'b0; frm_ext = 1'b0; frm_id = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1", "outputs after reset",
            64'({res_valid, res_hit, res_accept, res_index, res_action}), 64'd0);
      send("R1", 1'b0, 29'd0);
      send("R1", 1'b1, 29'd0);

      // R2: valid drops one cycle after a lone frame
      @(negedge clk);
      check("R2", "valid idle", 64'(res_valid), 64'd0);

      set_counts(1'b1, 28, 8);

      // R3: pair match
      write_rule(1'b0, 2, 0, 1, 29'h123, 29'h456);
      send("R3", 1'b0, 29'h123);
      send("R3", 1'b0, 29'h456);
      send("R3", 1'b0, 29'h124);

      // R4: inclusive range
      write_rule(1'b0, 3, 1, 2, 29'h200, 29'h20F);
      send("R4", 1'b0, 29'h200);
      send("R4", 1'b0, 29'h20F);
      send("R4", 1'b0, 29'h210);
      send("R4", 1'b0, 29'h1FF);

      // R5: value/mask on the extended list
      write_rule(1'b1, 1, 2, 3, 29'h1ABC0000, 29'h1FFF0000);
      send("R5", 1'b1, 29'h1ABC1234);
      send("R5", 1'b1, 29'h1ABD0000);

      // R10: list chosen by identifier type
      send("R10", 1'b1, 29'h123);
      send("R10", 1'b0, 29'h10000123);

      // R7: lowest index wins
      write_rule(1'b0, 5, 0, 4, 29'h123, 29'h7FF);
      send("R7", 1'b0, 29'h123);

      // R6: kind 3 never hits; all-zero rule disabled
      write_rule(1'b0, 2, 3, 1, 29'h123, 29'h456);
      send("R6", 1'b0, 29'h123);
      write_rule(1'b0, 0, 0, 0, 29'h0, 29'h0);
      send("R6", 1'b0, 29'h0);
      write_rule(1'b0, 1, 0, 1, 29'h0, 29'h0);
      send("R6", 1'b0, 29'h0);

      // R12: matching rule with reject action
      write_rule(1'b0, 4, 0, 0, 29'h300, 29'h301);
      send("R12", 1'b0, 29'h301);

      // R8: count limits search; over-large count clamps
      set_counts(1'b1, 4, 8);
      send("R8", 1'b0, 29'h123);
      set_counts(1'b1, 31, 15);
      write_rule(1'b0, 27, 0, 6, 29'h555, 29'h555);
      write_rule(1'b1, 7, 0, 5, 29'h0ABCDEF, 29'h0ABCDEF);
      send("R8", 1'b0, 29'h555);
      send("R8", 1'b1, 29'h0ABCDEF);

      // R11: upper bits of standard fields dropped
      write_rule(1'b0, 6, 0, 7, 29'h1F0000AB, 29'h1F0007FE);
      send("R11", 1'b0, 29'h0AB);
      send("R11", 1'b0, 29'h7FE);

      // R9: counts locked outside init, rules still writable
      set_counts(1'b0, 0, 0);
      send("R9", 1'b0, 29'h555);
      write_rule(1'b0, 27, 0, 6, 29'h556, 29'h556);
      send("R9", 1'b0, 29'h556);
      send("R9", 1'b0, 29'h555);

      // R13: writes past list depth ignored
      write_rule(1'b0, 30, 0, 1, 29'h777, 29'h777);
      send("R13", 1'b0, 29'h777);
      write_rule(1'b1, 9, 0, 1, 29'h1234, 29'h1234);
      send("R13", 1'b1, 29'h1234);

      // random rounds mixing all rules (R3 R4 R5 R7 R8)
      for (int r = 0; r < 4; r++) begin
         set_counts(1'b1, int'($urandom % 32), int'($urandom % 16));
         for (int k = 0; k < 24; k++) begin
            bit          ext;
            int          t;
            logic [28:0] f1, f2;
            ext = 1'($urandom % 2);
            t   = int'($urandom % 4);
            f1  = 29'($urandom % 64);
            case (t)
               1:       f2 = f1 + 29'($urandom % 16);
               2:       f2 = 29'($urandom % 64) | (ext ? 29'h1FFFFFC0 : 29'h7C0);
               default: f2 = 29'($urandom % 64);
            endcase
            if (!ext && ($urandom % 3) == 0) f1 = f1 | 29'($urandom << 11);
            write_rule(ext, int'($urandom % 32), t, int'($urandom % 8), f1, f2);
         end
         for (int k = 0; k < 80; k++) begin
            logic [28:0] id;
            id = 29'($urandom % 80);
            if (($urandom % 4) == 0) id = id | 29'($urandom << 11);
            send("R7", 1'($urandom % 2), id);
         end
      end

      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule